// File: doc/BRIEF.md
# Decimal (4221) Carry-Save Reducer

This block adds a parameterized number of decimal operands and returns the total in redundant form as two words, a sum word S and a carry word H. The operand sum equals S + 2·H. Every operand digit, and every digit of S and H, is a 4-bit vector with bit weights 4, 2, 2 and 1. All sixteen bit patterns are legal and stand for values from 0 to 9. Because these four weights add to exactly nine, bitwise binary full adders never produce an invalid digit. The block therefore needs no +6 decimal correction.

Each reduction stage is a bitwise 3:2 compressor. Its carry word is then brought to the same scale as the sum word by a decimal doubler. The doubler recodes each digit into a 5-2-1-1 weighted form and shifts the word left by one bit. The weight-5 bit leaves its digit as a decimal carry, and the carry from the digit below fills the freed low bit. The carry word of the last stage is delivered undoubled, so the consumer applies the final ×2 inside its own carry-propagate adder.

The block is purely combinational. Decimal carries out of the most significant digit are dropped, so the outputs are exact modulo 10^DIGITS.

Top module: `dcsa_tree`

## Requirements
- R1: For any inputs, value(sum_o) + 2·value(carry_o) equals the sum of the operand values, where a digit's value is 4·b3 + 2·b2 + 2·b1 + b0 and a word's value is the sum of its digits times 10^i. Digit i occupies bits [4i+3:4i].
- R2: Every one of the 16 bit patterns in any operand digit is accepted as its weighted value, including the redundant encodings of 2 through 7.
- R3: The digit recoder's output, read with weights 5, 2, 1, 1, equals its input read with weights 4, 2, 2, 1.
- R4: In the doubler, for each digit, twice the input digit value plus the incoming decimal carry equals the output digit value plus ten times the outgoing carry.
- R5: In each 3:2 stage, the three input values add up to the sum-word value plus twice the carry-word value. This holds per digit.
- R6: When the true total reaches 10^DIGITS or more, value(sum_o) + 2·value(carry_o) equals the total modulo 10^DIGITS.
- R7: All-zero operands produce sum_o and carry_o equal to all-zero bits.
- R8: carry_o is the last stage's carry word before doubling. For NUM_OPS = 3 with three operands each equal to 4'b0001, sum_o is 4'b0001 and carry_o is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ops_i | input | NUM_OPS × 4·DIGITS | Operands, each a word of 4-2-2-1 coded digits |
| sum_o | output | 4·DIGITS | Redundant sum word S |
| carry_o | output | 4·DIGITS | Undoubled carry word H; the total is S + 2·H |

## Verification
A narrow three-operand, two-digit configuration is swept over every combination of low-digit bit patterns. This separates a correct weighted decode of every redundant encoding from one that only handles the canonical patterns. A five-operand, six-digit configuration is driven with random patterns confined to the low digits, so the total always fits. It is then driven with patterns in every digit, which forces carries past the top and exercises the modular wrap. The zero pattern and the three-ones pattern tell a correct undoubled carry word apart from an early doubling or a stray carry.

// File: rtl/dcsa_pkg.sv
package dcsa_pkg;

  // Value of a digit read with weights 4,2,2,1
  function automatic int val_4221(input logic [3:0] d);
    return 4*int'(d[3]) + 2*int'(d[2]) + 2*int'(d[1]) + int'(d[0]);
  endfunction

  // Value of a digit read with weights 5,2,1,1
  function automatic int val_5211(input logic [3:0] d);
    return 5*int'(d[3]) + 2*int'(d[2]) + int'(d[1]) + int'(d[0]);
  endfunction

endpackage

// File: rtl/dcsa_rec5211.sv
module dcsa_rec5211
  import dcsa_pkg::*;
(
  input  logic [3:0] d_i,
  output logic [3:0] w_o
);

  int         v;
  int         r;
  logic       hi;
  logic [2:0] lo;

  always_comb begin
    v  = val_4221(d_i);
    hi = (v >= 5);
    r  = hi ? v - 5 : v;
    case (r)
      0:       lo = 3'b000;
      1:       lo = 3'b001;
      2:       lo = 3'b011;
      3:       lo = 3'b101;
      4:       lo = 3'b111;
      default: lo = 3'b000;
    endcase
    w_o = {hi, lo};
  end

  // R3: recoding preserves the digit value
  always_comb begin
    a_r3_value_kept: assert (val_5211(w_o) == val_4221(d_i));
  end

endmodule

// File: rtl/dcsa_dbl.sv
module dcsa_dbl
  import dcsa_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] h_i,
  output logic [W-1:0] t_o
);

  logic [DIGITS-1:0] cout;
  logic [DIGITS-1:0] cin;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] w;

    dcsa_rec5211 u_rec (
      .d_i (h_i[4*i +: 4]),
      .w_o (w)
    );

    assign cout[i] = w[3];
    if (i == 0) begin : g_lsd
      assign cin[i] = 1'b0;
    end else begin : g_up
      assign cin[i] = cout[i-1];
    end
    assign t_o[4*i +: 4] = {w[2:0], cin[i]};

    // R4: doubling with decimal carry in and out
    always_comb begin
      a_r4_double: assert (2*val_4221(h_i[4*i +: 4]) + int'(cin[i])
                           == val_4221(t_o[4*i +: 4]) + 10*int'(cout[i]));
    end
  end

endmodule

// File: rtl/dcsa_fa3.sv
module dcsa_fa3
  import dcsa_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] h_o
);

  assign s_o = a_i ^ b_i ^ c_i;
  assign h_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

  // R5: per-digit carry-save identity
  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    always_comb begin
      a_r5_csa_identity: assert (val_4221(a_i[4*i +: 4]) + val_4221(b_i[4*i +: 4])
                                 + val_4221(c_i[4*i +: 4])
                                 == val_4221(s_o[4*i +: 4]) + 2*val_4221(h_o[4*i +: 4]));
    end
  end

endmodule

// File: rtl/dcsa_tree.sv
module dcsa_tree #(
  parameter int NUM_OPS = 5,
  parameter int DIGITS  = 4,
  localparam int W      = 4 * DIGITS,
  localparam int STAGES = NUM_OPS - 2
) (
  input  logic [NUM_OPS-1:0][W-1:0] ops_i,
  output logic [W-1:0]              sum_o,
  output logic [W-1:0]              carry_o
);

  // Chain of 3:2 stages; every carry word except the last is doubled
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] a, b, s, h;

    if (k == 0) begin : g_first
      assign a = ops_i[0];
      assign b = ops_i[1];
    end else begin : g_next
      assign a = g_stage[k-1].s;
      assign b = g_stage[k-1].g_dbl.t;
    end

    dcsa_fa3 #(.DIGITS(DIGITS)) u_fa3 (
      .a_i (a),
      .b_i (b),
      .c_i (ops_i[k+2]),
      .s_o (s),
      .h_o (h)
    );

    if (k < STAGES - 1) begin : g_dbl
      logic [W-1:0] t;
      dcsa_dbl #(.DIGITS(DIGITS)) u_dbl (
        .h_i (h),
        .t_o (t)
      );
    end
  end

  assign sum_o   = g_stage[STAGES-1].s;
  assign carry_o = g_stage[STAGES-1].h;

  // R7: zero operands give zero outputs
  always_comb begin
    if (ops_i == '0) begin
      a_r7_zero_out: assert (sum_o == '0 && carry_o == '0);
    end
  end

endmodule

// File: tb/dcsa_tree_bench.sv
module dcsa_tree_bench;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Wide configuration: 5 operands, 6 digits
  logic [4:0][23:0] ops_a;
  logic [23:0]      s_a, h_a;
  dcsa_tree #(.NUM_OPS(5), .DIGITS(6)) u_dcsa_tree (
    .ops_i (ops_a), .sum_o (s_a), .carry_o (h_a)
  );

  // Narrow configuration: 3 operands, 2 digits
  logic [2:0][7:0] ops_b;
  logic [7:0]      s_b, h_b;
  dcsa_tree #(.NUM_OPS(3), .DIGITS(2)) u_dcsa_tree_n (
    .ops_i (ops_b), .sum_o (s_b), .carry_o (h_b)
  );

  function automatic longint dec(input logic [23:0] w, input int nd);
    longint acc = 0;
    for (int i = nd - 1; i >= 0; i--) begin
      acc = acc * 10 + 4*w[4*i+3] + 2*w[4*i+2] + 2*w[4*i+1] + w[4*i];
    end
    return acc;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    longint tot;
    rst_n = 1'b0;
    ops_a = '0;
    ops_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R7: zero operands give all-zero bits
    @(negedge clk);
    chk("R7 sum_a", longint'(s_a), 0);
    chk("R7 carry_a", longint'(h_a), 0);
    chk("R7 sum_b", longint'(s_b), 0);
    chk("R7 carry_b", longint'(h_b), 0);

    // R8: carry word leaves undoubled
    @(posedge clk);
    ops_b = {8'h01, 8'h01, 8'h01};
    @(negedge clk);
    chk("R8 sum bits", longint'(s_b), 1);
    chk("R8 carry bits", longint'(h_b), 1);

    // R2, R1: every low-digit pattern combination, narrow config
    for (int p = 0; p < 4096; p++) begin
      @(posedge clk);
      ops_b = {4'h0, p[11:8], 4'h0, p[7:4], 4'h0, p[3:0]};
      @(negedge clk);
      tot = dec({16'h0, ops_b[0]}, 2) + dec({16'h0, ops_b[1]}, 2) + dec({16'h0, ops_b[2]}, 2);
      chk("R2 R1 sweep", dec({16'h0, s_b}, 2) + 2 * dec({16'h0, h_b}, 2), tot);
    end

    // R1 (via R3 R4 R5): all-nines in live digits
    @(posedge clk);
    for (int k = 0; k < 5; k++) ops_a[k] = 24'h00FFFF;
    @(negedge clk);
    chk("R1 nines", dec(s_a, 6) + 2 * dec(h_a, 6), 5 * 9999);

    // R1 R3 R4 R5: random patterns, total fits
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk);
      tot = 0;
      for (int k = 0; k < 5; k++) ops_a[k] = {8'h00, 16'($urandom)};
      @(negedge clk);
      for (int k = 0; k < 5; k++) tot += dec(ops_a[k], 6);
      chk("R1 R3 R4 R5 random", dec(s_a, 6) + 2 * dec(h_a, 6), tot);
    end

    // R6: patterns in every digit, wrap modulo 10^6
    for (int n = 0; n < 1000; n++) begin
      @(posedge clk);
      tot = 0;
      for (int k = 0; k < 5; k++) ops_a[k] = 24'($urandom);
      if (n == 0) for (int k = 0; k < 5; k++) ops_a[k] = 24'hFFFFFF;
      @(negedge clk);
      for (int k = 0; k < 5; k++) tot += dec(ops_a[k], 6);
      chk("R6 wrap", (dec(s_a, 6) + 2 * dec(h_a, 6)) % 1000000, tot % 1000000);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule